// File: doc/BRIEF.md
# Memory-Side Request Arbiter

This block decides which outstanding request goes out on the memory-side bus next. It watches three sources: a miss queue, a writeback buffer and a prefetch source. Each queue entry carries a byte address, a size in bytes and an allocation order number. Misses normally win. Two things override that rule. First, a write buffer that is full and has nothing in service forces writes out, unless an older miss covers the same bytes. Second, when the buffer is not full, a pending writeback that covers the chosen miss's bytes goes first, so the dirty data reaches memory before the line is fetched again.

The selection is combinational from the queue state to the request outputs. When the bus accepts the request, a one-cycle strobe on the following cycle tells the owning queue which entry to mark as in service. If the bus refuses the request, the arbiter stops offering requests until the bus signals a retry, and the refused entry stays pending. Responses waiting for the port take precedence, so `rsp_hold` suppresses every new request.

Top module: `memreq_arbiter`

## Requirements
- R1: If misses are pending and no writeback is pending, the request is the miss entry with the oldest order number, with source code 1. Entry a is older than entry b when bit ORD_W-1 of (a - b) mod 2^ORD_W is set.
- R2: If writebacks are pending and no miss is pending, the request is the oldest pending writeback entry, with source code 2.
- R3: If both are pending, the buffer is not (full with no entry in service), and no pending writeback overlaps the oldest miss, the oldest miss is issued.
- R4: If both are pending, the buffer is not (full with no entry in service), and some pending writeback overlaps the oldest miss, the oldest such overlapping writeback is issued.
- R5: If both are pending and every write-buffer slot is used with no entry in service, the oldest pending miss that overlaps the oldest writeback is issued if it is older than that writeback. Otherwise the oldest writeback is issued.
- R6: With nothing pending in either queue, a prefetch is issued (source code 3, index 0, size LINE_BYTES) only when `pf_valid` is high and at least one miss slot is unused.
- R7: While `rsp_hold` is high, `req_valid` is low.
- R8: A request offered with `bus_accept` high produces `svc_valid` for exactly the next cycle, carrying that request's source and index. There is no strobe otherwise.
- R9: A request offered with `bus_accept` low suppresses `req_valid` from the next cycle on. Requests resume on the cycle after `bus_retry` is sampled high.
- R10: Two requests overlap when their byte ranges [addr, addr+size) intersect. Adjacent ranges and zero-size ranges never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_used | input | MISS_N | Miss slots occupied |
| miss_pend | input | MISS_N | Miss entries awaiting issue |
| miss_addr | input | MISS_N x ADDR_W | Miss byte addresses |
| miss_size | input | MISS_N x SIZE_W | Miss sizes in bytes |
| miss_order | input | MISS_N x ORD_W | Miss allocation order |
| wb_used | input | WB_N | Write-buffer slots occupied |
| wb_pend | input | WB_N | Writebacks awaiting issue |
| wb_busy | input | WB_N | Writebacks in service |
| wb_addr | input | WB_N x ADDR_W | Writeback byte addresses |
| wb_size | input | WB_N x SIZE_W | Writeback sizes |
| wb_order | input | WB_N x ORD_W | Writeback allocation order |
| pf_valid | input | 1 | Prefetch candidate available |
| pf_addr | input | ADDR_W | Prefetch line address |
| rsp_hold | input | 1 | A response owns the port this cycle |
| bus_accept | input | 1 | Bus takes the offered request |
| bus_retry | input | 1 | Bus invites a retry after a refusal |
| req_valid | output | 1 | Request offered |
| req_src | output | 2 | 0 none, 1 miss, 2 writeback, 3 prefetch |
| req_idx | output | IDX_W | Entry index in its queue |
| req_addr | output | ADDR_W | Request address |
| req_size | output | SIZE_W | Request size |
| svc_valid | output | 1 | Mark-in-service strobe |
| svc_src | output | 2 | Source of the accepted request |
| svc_idx | output | IDX_W | Index of the accepted request |

## Verification
The bench sweeps every pairing of miss and writeback pending masks. It runs them under a full idle buffer, a full buffer with one entry in service, and a buffer with a free slot, using address layouts that create partial overlaps and order numbers that wrap past zero. A design that compared order numbers without wrap handling would pick the wrong miss around the wrap. A design that skipped the full-buffer override would starve writes, and one that ignored the overlap search would let a miss pass a dirty writeback. Directed cases probe adjacent and zero-size ranges, where an off-by-one overlap test would wrongly issue the writeback. They also probe the refusal and retry sequence, where a design that dropped the wait state would keep offering requests to a bus that refused them.

// File: rtl/memreq_pkg.sv
package memreq_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MISS = 2'd1,
        SRC_WB   = 2'd2,
        SRC_PF   = 2'd3
    } req_src_e;
endpackage

// File: rtl/memreq_range_overlap.sv
module memreq_range_overlap #(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 7
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [SIZE_W-1:0] b_size,
    output logic              hit
);
    localparam int EW = ADDR_W + 1;
    logic [EW-1:0] a_end, b_end;

    always_comb begin
        a_end = {1'b0, a_addr} + EW'(a_size);
        b_end = {1'b0, b_addr} + EW'(b_size);
        hit   = (a_size != '0) && (b_size != '0) &&
                ({1'b0, a_addr} < b_end) && ({1'b0, b_addr} < a_end);
    end
endmodule

// File: rtl/memreq_oldest_pick.sv
module memreq_oldest_pick #(
    parameter int N  = 4,
    parameter int OW = 6,
    parameter int IW = 2
) (
    input  logic [N-1:0]         cand,
    input  logic [N-1:0][OW-1:0] order,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [OW-1:0] best;
    logic [OW-1:0] diff;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        diff  = '0;
        for (int i = 0; i < N; i++) begin
            diff = order[i] - best;
            if (cand[i] && (!found || diff[OW-1])) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = order[i];
            end
        end
    end
endmodule

// File: rtl/memreq_arbiter.sv
module memreq_arbiter #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 7,
    parameter int ORD_W      = 6,
    parameter int MISS_N     = 4,
    parameter int WB_N       = 4,
    parameter int LINE_BYTES = 64,
    parameter int IDX_W      = ((MISS_N > WB_N ? MISS_N : WB_N) > 1) ?
                               $clog2(MISS_N > WB_N ? MISS_N : WB_N) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [MISS_N-1:0]              miss_used,
    input  logic [MISS_N-1:0]              miss_pend,
    input  logic [MISS_N-1:0][ADDR_W-1:0]  miss_addr,
    input  logic [MISS_N-1:0][SIZE_W-1:0]  miss_size,
    input  logic [MISS_N-1:0][ORD_W-1:0]   miss_order,
    input  logic [WB_N-1:0]                wb_used,
    input  logic [WB_N-1:0]                wb_pend,
    input  logic [WB_N-1:0]                wb_busy,
    input  logic [WB_N-1:0][ADDR_W-1:0]    wb_addr,
    input  logic [WB_N-1:0][SIZE_W-1:0]    wb_size,
    input  logic [WB_N-1:0][ORD_W-1:0]     wb_order,
    input  logic                           pf_valid,
    input  logic [ADDR_W-1:0]              pf_addr,
    input  logic                           rsp_hold,
    input  logic                           bus_accept,
    input  logic                           bus_retry,
    output logic                           req_valid,
    output logic [1:0]                     req_src,
    output logic [IDX_W-1:0]               req_idx,
    output logic [ADDR_W-1:0]              req_addr,
    output logic [SIZE_W-1:0]              req_size,
    output logic                           svc_valid,
    output logic [1:0]                     svc_src,
    output logic [IDX_W-1:0]               svc_idx
);
    import memreq_pkg::*;

    localparam int MIW = (MISS_N > 1) ? $clog2(MISS_N) : 1;
    localparam int WIW = (WB_N > 1) ? $clog2(WB_N) : 1;

    typedef struct packed {
        logic             hold_off;
        logic             svc_v;
        req_src_e         svc_src;
        logic [IDX_W-1:0] svc_idx;
    } arb_state_t;

    arb_state_t st_d, st_q;

    function automatic logic is_older(input logic [ORD_W-1:0] a,
                                      input logic [ORD_W-1:0] b);
        logic [ORD_W-1:0] d;
        d = a - b;
        return d[ORD_W-1];
    endfunction

    // oldest pending entry of each queue
    logic           m_found, w_found, mc_found, wc_found;
    logic [MIW-1:0] m_idx, mc_idx;
    logic [WIW-1:0] w_idx, wc_idx;

    memreq_oldest_pick #(.N(MISS_N), .OW(ORD_W), .IW(MIW)) u_miss_old (
        .cand(miss_pend), .order(miss_order), .found(m_found), .idx(m_idx));
    memreq_oldest_pick #(.N(WB_N), .OW(ORD_W), .IW(WIW)) u_wb_old (
        .cand(wb_pend), .order(wb_order), .found(w_found), .idx(w_idx));

    // cross-queue overlap vectors
    logic [MISS_N-1:0] m_hits_w;
    logic [WB_N-1:0]   w_hits_m;

    genvar gi;
    generate
        for (gi = 0; gi < MISS_N; gi++) begin : g_miss_ovl
            memreq_range_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
                .a_addr(miss_addr[gi]), .a_size(miss_size[gi]),
                .b_addr(wb_addr[w_idx]), .b_size(wb_size[w_idx]),
                .hit(m_hits_w[gi]));
        end
        for (gi = 0; gi < WB_N; gi++) begin : g_wb_ovl
            memreq_range_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ovl (
                .a_addr(wb_addr[gi]), .a_size(wb_size[gi]),
                .b_addr(miss_addr[m_idx]), .b_size(miss_size[m_idx]),
                .hit(w_hits_m[gi]));
        end
    endgenerate

    // oldest conflicting entry in the opposite queue
    memreq_oldest_pick #(.N(MISS_N), .OW(ORD_W), .IW(MIW)) u_miss_conf (
        .cand(miss_pend & m_hits_w), .order(miss_order),
        .found(mc_found), .idx(mc_idx));
    memreq_oldest_pick #(.N(WB_N), .OW(ORD_W), .IW(WIW)) u_wb_conf (
        .cand(wb_pend & w_hits_m), .order(wb_order),
        .found(wc_found), .idx(wc_idx));

    req_src_e         sel_src;
    logic [IDX_W-1:0] sel_idx;
    logic             wb_drain;
    logic             miss_room;

    always_comb begin
        sel_src   = SRC_NONE;
        sel_idx   = '0;
        wb_drain  = (&wb_used) && !(|wb_busy);
        miss_room = !(&miss_used);

        if (!rsp_hold && !st_q.hold_off) begin
            if (m_found && !w_found) begin
                sel_src = SRC_MISS;
                sel_idx = IDX_W'(m_idx);
            end else if (w_found && !m_found) begin
                sel_src = SRC_WB;
                sel_idx = IDX_W'(w_idx);
            end else if (m_found && w_found) begin
                if (wb_drain) begin
                    if (mc_found && is_older(miss_order[mc_idx], wb_order[w_idx])) begin
                        sel_src = SRC_MISS;
                        sel_idx = IDX_W'(mc_idx);
                    end else begin
                        sel_src = SRC_WB;
                        sel_idx = IDX_W'(w_idx);
                    end
                end else if (wc_found) begin
                    sel_src = SRC_WB;
                    sel_idx = IDX_W'(wc_idx);
                end else begin
                    sel_src = SRC_MISS;
                    sel_idx = IDX_W'(m_idx);
                end
            end else if (pf_valid && miss_room) begin
                sel_src = SRC_PF;
            end
        end

        req_valid = (sel_src != SRC_NONE);
        req_src   = sel_src;
        req_idx   = sel_idx;
        case (sel_src)
            SRC_MISS: begin
                req_addr = miss_addr[sel_idx[MIW-1:0]];
                req_size = miss_size[sel_idx[MIW-1:0]];
            end
            SRC_WB: begin
                req_addr = wb_addr[sel_idx[WIW-1:0]];
                req_size = wb_size[sel_idx[WIW-1:0]];
            end
            SRC_PF: begin
                req_addr = pf_addr;
                req_size = SIZE_W'(LINE_BYTES);
            end
            default: begin
                req_addr = '0;
                req_size = '0;
            end
        endcase

        st_d.hold_off = st_q.hold_off ? !bus_retry : (req_valid && !bus_accept);
        st_d.svc_v    = req_valid && bus_accept;
        st_d.svc_src  = (req_valid && bus_accept) ? sel_src : SRC_NONE;
        st_d.svc_idx  = (req_valid && bus_accept) ? sel_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{hold_off: 1'b0, svc_v: 1'b0, svc_src: SRC_NONE, svc_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign svc_valid = st_q.svc_v;
    assign svc_src   = st_q.svc_src;
    assign svc_idx   = st_q.svc_idx;
endmodule

// File: rtl/memreq_arbiter_chk.sv
module memreq_arbiter_chk #(
    parameter int SIZE_W     = 7,
    parameter int MISS_N     = 4,
    parameter int WB_N       = 4,
    parameter int LINE_BYTES = 64,
    parameter int IDX_W      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MISS_N-1:0] miss_used,
    input logic [MISS_N-1:0] miss_pend,
    input logic [WB_N-1:0]   wb_pend,
    input logic              pf_valid,
    input logic              rsp_hold,
    input logic              bus_accept,
    input logic              req_valid,
    input logic [1:0]        req_src,
    input logic [IDX_W-1:0]  req_idx,
    input logic [SIZE_W-1:0] req_size,
    input logic              svc_valid,
    input logic [1:0]        svc_src,
    input logic [IDX_W-1:0]  svc_idx
);
    AST_MISS_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd1) |-> (32'(req_idx) < MISS_N) && miss_pend[req_idx]); // R1
    AST_WB_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd2) |-> (32'(req_idx) < WB_N) && wb_pend[req_idx]); // R2
    AST_PF_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == 2'd3) |-> (!(|miss_pend) && !(|wb_pend) && !(&miss_used)
                                            && pf_valid && req_size == SIZE_W'(LINE_BYTES))); // R6
    AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hold |-> !req_valid); // R7
    AST_SVC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bus_accept) |=> (svc_valid && svc_src == $past(req_src)
                                       && svc_idx == $past(req_idx))); // R8
    AST_NO_SVC_UNACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && bus_accept) |=> !svc_valid); // R8
    AST_QUIET_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_accept) |=> !req_valid); // R9
endmodule

bind memreq_arbiter memreq_arbiter_chk #(
    .SIZE_W(SIZE_W), .MISS_N(MISS_N), .WB_N(WB_N),
    .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .miss_used(miss_used), .miss_pend(miss_pend),
    .wb_pend(wb_pend), .pf_valid(pf_valid), .rsp_hold(rsp_hold),
    .bus_accept(bus_accept), .req_valid(req_valid), .req_src(req_src),
    .req_idx(req_idx), .req_size(req_size), .svc_valid(svc_valid),
    .svc_src(svc_src), .svc_idx(svc_idx)
);

// File: tb/memreq_arbiter_bench.sv
module memreq_arbiter_bench;
    localparam int AW = 16, SW = 7, OW = 6, N = 4, LB = 64, IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]         miss_used, miss_pend, wb_used, wb_pend, wb_busy;
    logic [N-1:0][AW-1:0] miss_addr, wb_addr;
    logic [N-1:0][SW-1:0] miss_size, wb_size;
    logic [N-1:0][OW-1:0] miss_order, wb_order;
    logic                 pf_valid, rsp_hold, bus_accept, bus_retry;
    logic [AW-1:0]        pf_addr;
    logic                 req_valid, svc_valid;
    logic [1:0]           req_src, svc_src;
    logic [IW-1:0]        req_idx, svc_idx;
    logic [AW-1:0]        req_addr;
    logic [SW-1:0]        req_size;

    memreq_arbiter u_memreq_arbiter (
        .clk(clk), .rst_n(rst_n),
        .miss_used(miss_used), .miss_pend(miss_pend), .miss_addr(miss_addr),
        .miss_size(miss_size), .miss_order(miss_order),
        .wb_used(wb_used), .wb_pend(wb_pend), .wb_busy(wb_busy),
        .wb_addr(wb_addr), .wb_size(wb_size), .wb_order(wb_order),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .rsp_hold(rsp_hold),
        .bus_accept(bus_accept), .bus_retry(bus_retry),
        .req_valid(req_valid), .req_src(req_src), .req_idx(req_idx),
        .req_addr(req_addr), .req_size(req_size),
        .svc_valid(svc_valid), .svc_src(svc_src), .svc_idx(svc_idx));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // wrap-safe age: a older than b when (a-b) mod 64 >= 32
    function automatic bit older(input int a, input int b);
        return ((a - b) & 63) >= 32;
    endfunction

    function automatic bit ovl(input int a, input int s, input int b, input int t);
        return (s > 0) && (t > 0) && (a < b + t) && (b < a + s);
    endfunction

    function automatic int oldest_miss(input logic [N-1:0] mask);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (mask[i] && (best < 0 || older(int'(miss_order[i]), int'(miss_order[best]))))
                best = i;
        return best;
    endfunction

    function automatic int oldest_wb(input logic [N-1:0] mask);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (mask[i] && (best < 0 || older(int'(wb_order[i]), int'(wb_order[best]))))
                best = i;
        return best;
    endfunction

    // reference selection: src 0 none,1 miss,2 wb,3 pf
    task automatic model(output int src, output int idx, output string tag);
        int mi, wi, mc, wc;
        logic [N-1:0] mm, wm;
        mi = oldest_miss(miss_pend);
        wi = oldest_wb(wb_pend);
        src = 0; idx = 0; tag = "R6";
        if (mi >= 0 && wi < 0) begin
            src = 1; idx = mi; tag = "R1";
        end else if (wi >= 0 && mi < 0) begin
            src = 2; idx = wi; tag = "R2";
        end else if (mi >= 0 && wi >= 0) begin
            if (wb_used == 4'hF && wb_busy == 4'h0) begin
                for (int i = 0; i < N; i++)
                    mm[i] = miss_pend[i] && ovl(int'(miss_addr[i]), int'(miss_size[i]),
                                                int'(wb_addr[wi]), int'(wb_size[wi]));
                mc = oldest_miss(mm);
                tag = "R5";
                if (mc >= 0 && older(int'(miss_order[mc]), int'(wb_order[wi]))) begin
                    src = 1; idx = mc;
                end else begin
                    src = 2; idx = wi;
                end
            end else begin
                for (int i = 0; i < N; i++)
                    wm[i] = wb_pend[i] && ovl(int'(wb_addr[i]), int'(wb_size[i]),
                                              int'(miss_addr[mi]), int'(miss_size[mi]));
                wc = oldest_wb(wm);
                if (wc >= 0) begin
                    src = 2; idx = wc; tag = "R4";
                end else begin
                    src = 1; idx = mi; tag = "R3";
                end
            end
        end else if (pf_valid && miss_used != 4'hF) begin
            src = 3; idx = 0;
        end
    endtask

    task automatic clear_inputs();
        miss_used = '0; miss_pend = '0; miss_addr = '0; miss_size = '0; miss_order = '0;
        wb_used = '0; wb_pend = '0; wb_busy = '0; wb_addr = '0; wb_size = '0; wb_order = '0;
        pf_valid = 1'b0; pf_addr = 16'h0800; rsp_hold = 1'b0;
        bus_accept = 1'b1; bus_retry = 1'b0;
    endtask

    // drive at negedge, check combinational request, then strobe after the edge
    task automatic step_and_check();
        int es, ei;
        string tg;
        #1;
        model(es, ei, tg);
        chk(tg, int'(req_src), es);
        if (es != 0) chk(tg, int'(req_idx), ei);
        if (es == 1) chk(tg, int'(req_addr), int'(miss_addr[ei]));
        if (es == 2) chk(tg, int'(req_size), int'(wb_size[ei]));
        if (es == 3) chk("R6", int'(req_size), LB);
        @(posedge clk); #1;
        chk("R8", int'(svc_valid), (es != 0) ? 1 : 0);
        if (es != 0) chk("R8", int'(svc_src) * 4 + int'(svc_idx), es * 4 + ei);
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("reset", int'(req_valid), 0);
        chk("reset", int'(svc_valid), 0);

        // sweep: four layouts x three buffer states x all pending masks
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 3; v++) begin
                for (int mp = 0; mp < 16; mp++) begin
                    for (int wp = 0; wp < 16; wp++) begin
                        @(negedge clk);
                        for (int i = 0; i < N; i++) begin
                            miss_addr[i]  = AW'(256 + i * 32);
                            miss_size[i]  = (i == s) ? SW'(0) : SW'(16);
                            miss_order[i] = OW'((60 + i * 3 + s * 7) & 63);
                            wb_addr[i]    = AW'(256 + i * 24 + s * 4);
                            wb_size[i]    = SW'(8 + 4 * i);
                            wb_order[i]   = OW'((58 + i * 5 + s * 2) & 63);
                        end
                        wb_busy   = (v == 1) ? 4'b0001 : 4'b0000;
                        wb_used   = (v == 2) ? 4'b0111 : 4'b1111;
                        wb_pend   = 4'(wp) & ~wb_busy & wb_used;
                        miss_pend = 4'(mp);
                        miss_used = s[0] ? 4'hF : 4'(mp);
                        pf_valid  = 1'b1;
                        step_and_check();
                    end
                end
            end
        end

        // R10: adjacent ranges do not overlap, so the miss goes first (R3 path)
        @(negedge clk);
        clear_inputs();
        miss_pend = 4'b0001; miss_used = 4'b0001;
        miss_addr[0] = 16'h0100; miss_size[0] = 7'd8; miss_order[0] = 6'd0;
        wb_pend = 4'b0001; wb_used = 4'b0001;
        wb_addr[0] = 16'h0108; wb_size[0] = 7'd8; wb_order[0] = 6'd1;
        #1;
        chk("R10", int'(req_src), 1);
        @(negedge clk);
        wb_addr[0] = 16'h0107; wb_size[0] = 7'd1;
        #1;
        chk("R10", int'(req_src), 2);
        @(negedge clk);
        wb_addr[0] = 16'h0100; wb_size[0] = 7'd0;
        #1;
        chk("R10", int'(req_src), 1);

        // R7: pending response blocks new requests
        @(negedge clk);
        rsp_hold = 1'b1;
        #1;
        chk("R7", int'(req_valid), 0);
        @(negedge clk);
        rsp_hold = 1'b0;
        #1;
        chk("R7", int'(req_valid), 1);

        // R9: refusal then retry
        @(negedge clk);
        bus_accept = 1'b0;
        #1;
        chk("R9", int'(req_valid), 1);
        @(negedge clk); #1;
        chk("R9", int'(req_valid), 0);
        chk("R9", int'(svc_valid), 0);
        @(negedge clk); #1;
        chk("R9", int'(req_valid), 0);
        bus_retry = 1'b1;
        @(negedge clk);
        bus_retry = 1'b0;
        bus_accept = 1'b1;
        #1;
        chk("R9", int'(req_valid), 1);
        chk("R9", int'(req_src), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule